// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block performs one iteration of a bit-serial non-restoring division. Each iteration takes a partial remainder, a divisor and three status bits. The status bits are the running quotient-sign bit `q`, the divisor-sign bit `m` and the quotient output bit `t`. The block produces the next partial remainder and the next values of `q` and `t`. Software or a sequencer issues one step per quotient bit. It feeds the registered results back as the next step's operands and status bits, so a full division is a chain of steps.

Within a step, the partial remainder is shifted one place left and the current `t` enters at the bottom. The divisor is then subtracted when `q` and `m` agree and added when they differ. The new `q` comes from the bit that was shifted out, the carry or borrow of that add or subtract, and the old `q`/`m` pair. The new `t` is set when the new `q` matches `m`. The setup that first loads `q` and `m`, and the loop that repeats the step, belong to the caller.

Top module: `divstep_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released with no step issued, `rem_o`, `q_o` and `t_o` are all 0.
- R2: In a step, the remainder operand is shifted left by one bit. `t_i` fills bit 0, and the former bit W-1 becomes the shifted-out bit.
- R3: When `q_i` equals `m_i`, `rem_o` becomes the shifted value minus `dvs_i`, modulo 2^W.
- R4: When `q_i` differs from `m_i`, `rem_o` becomes the shifted value plus `dvs_i`, modulo 2^W.
- R5: On a subtraction, the flag is 1 when the result, read as unsigned, exceeds the shifted value (a borrow). On an addition, the flag is 1 when the result is below the shifted value (a carry).
- R6: The new `q_o` depends on the pair {`q_i`,`m_i`}. For 00 and 11 it equals the flag when the shifted-out bit is 0, and the inverted flag when that bit is 1. For 01 and 10 it equals the inverted flag when the shifted-out bit is 0, and the flag when that bit is 1.
- R7: The new `t_o` is 1 exactly when the new `q_o` equals `m_i`.
- R8: With `step_i` low, `rem_o`, `q_o` and `t_o` keep their values whatever the other inputs do.
- R9: The results of a step with `step_i` high at a rising edge appear together after that edge. Steps may be issued on consecutive cycles, each step using the previous step's registered outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Perform one division step at this edge |
| dvd_i | input | W (32) | Partial remainder operand |
| dvs_i | input | W (32) | Divisor operand |
| q_i | input | 1 | Current quotient-sign status bit |
| m_i | input | 1 | Divisor-sign status bit |
| t_i | input | 1 | Current quotient output bit, shifted in |
| rem_o | output | W (32) | Registered new partial remainder |
| q_o | output | 1 | Registered new quotient-sign bit |
| t_o | output | 1 | Registered new quotient output bit |

## Verification
All three results of a step pass through a single register stage, so they are due at the rising edge where `step_i` is sampled high. They are readable from that edge until the next step. The bench drives operands and the strobe on the falling edge. It lowers the strobe on the next falling edge and reads all three outputs there, half a cycle after the updating edge. For back-to-back steps, each result is read on the falling edge that follows its own updating edge, before the next edge can overwrite it.

// File: rtl/divstep_pkg.sv
package divstep_pkg;

  // Operation chosen for the divisor in one step
  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } dstep_op_e;

endpackage

// File: rtl/divstep_shift.sv
module divstep_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] dvd_i,
  input  logic         t_i,
  output logic [W-1:0] shifted_o,
  output logic         msb_o
);

  function automatic logic [W:0] shl_insert(input logic [W-1:0] v, input logic fill);
    return {v, fill};
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide      = shl_insert(dvd_i, t_i);
    shifted_o = wide[W-1:0];
    msb_o     = wide[W];
  end

endmodule

// File: rtl/divstep_addsub.sv
module divstep_addsub
  import divstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  dstep_op_e    op_i,
  output logic [W-1:0] res_o,
  output logic         flag_o
);

  // Bit W of the widened result is the borrow (sub) or carry (add).
  function automatic logic [W:0] addsub_f(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input dstep_op_e op);
    logic [W:0] r;
    if (op == OP_SUB) r = {1'b0, a} - {1'b0, b};
    else              r = {1'b0, a} + {1'b0, b};
    return r;
  endfunction

  logic [W:0] full;

  always_comb begin
    full   = addsub_f(a_i, b_i, op_i);
    res_o  = full[W-1:0];
    flag_o = full[W];
  end

endmodule

// File: rtl/divstep_qsel.sv
module divstep_qsel (
  input  logic msb_i,
  input  logic flag_i,
  input  logic q_old_i,
  input  logic m_i,
  output logic q_new_o,
  output logic t_new_o
);

  // Parity form of the four-case table: agreeing q/m pass msb^flag,
  // differing q/m invert it.
  function automatic logic q_next_f(input logic msb, input logic flag,
                                    input logic q_old, input logic m);
    return msb ^ flag ^ q_old ^ m;
  endfunction

  always_comb begin
    q_new_o = q_next_f(msb_i, flag_i, q_old_i, m_i);
    t_new_o = (q_new_o == m_i);
  end

endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  output logic [W-1:0] rem_o,
  output logic         q_o,
  output logic         t_o
);

  // Named internal events
  logic [W-1:0] shifted_w;
  logic         msb_out_w;
  dstep_op_e    op_w;
  logic [W-1:0] sum_w;
  logic         flag_w;
  logic         q_next_w;
  logic         t_next_w;

  logic [W-1:0] rem_q;
  logic         q_q;
  logic         t_q;

  assign op_w = (q_i == m_i) ? OP_SUB : OP_ADD;

  divstep_shift #(.W(W)) u_shift (
    .dvd_i     (dvd_i),
    .t_i       (t_i),
    .shifted_o (shifted_w),
    .msb_o     (msb_out_w)
  );

  divstep_addsub #(.W(W)) u_addsub (
    .a_i    (shifted_w),
    .b_i    (dvs_i),
    .op_i   (op_w),
    .res_o  (sum_w),
    .flag_o (flag_w)
  );

  divstep_qsel u_qsel (
    .msb_i   (msb_out_w),
    .flag_i  (flag_w),
    .q_old_i (q_i),
    .m_i     (m_i),
    .q_new_o (q_next_w),
    .t_new_o (t_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      q_q   <= 1'b0;
      t_q   <= 1'b0;
    end else if (step_i) begin
      rem_q <= sum_w;
      q_q   <= q_next_w;
      t_q   <= t_next_w;
    end
  end

  assign rem_o = rem_q;
  assign q_o   = q_q;
  assign t_o   = t_q;

endmodule

// File: rtl/divstep_chk.sv
module divstep_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_i,
  input logic [W-1:0] dvd_i,
  input logic [W-1:0] dvs_i,
  input logic         q_i,
  input logic         m_i,
  input logic         t_i,
  input logic [W-1:0] rem_o,
  input logic         q_o,
  input logic         t_o
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (rem_o == '0) && !q_o && !t_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(rem_o) && $stable(q_o) && $stable(t_o));

  // R3
  sub_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (q_i == m_i)) |=>
      rem_o == ($past({dvd_i[W-2:0], t_i}) - $past(dvs_i)));

  // R4
  add_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (q_i != m_i)) |=>
      rem_o == ($past({dvd_i[W-2:0], t_i}) + $past(dvs_i)));

  // R7
  t_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> t_o == (q_o == $past(m_i)));

  // R5
  zero_divisor_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && (q_i == m_i) && (dvs_i == '0)) |=> q_o == $past(dvd_i[W-1]));

endmodule

bind divstep_unit divstep_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .step_i (step_i),
  .dvd_i  (dvd_i),
  .dvs_i  (dvs_i),
  .q_i    (q_i),
  .m_i    (m_i),
  .t_i    (t_i),
  .rem_o  (rem_o),
  .q_o    (q_o),
  .t_o    (t_o)
);

// File: tb/divstep_unit_tb.sv
`timescale 1ns/1ps
module divstep_unit_tb;

  localparam int W = 32;
  localparam int NV = 9;

  typedef struct packed {
    logic [W-1:0] dvd;
    logic [W-1:0] dvs;
    logic         q;
    logic         m;
    logic         t;
  } vec_t;

  // Stimulus vectors; expected results come from ref_step below.
  localparam vec_t VEC [NV] = '{
    '{32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 1'b1},
    '{32'h0000_0001, 32'h0000_0005, 1'b0, 1'b0, 1'b0},
    '{32'h8000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b0},
    '{32'h4000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0, 1'b1},
    '{32'h1234_5678, 32'h0F0F_0F0F, 1'b1, 1'b1, 1'b0},
    '{32'h8765_4321, 32'hFFFF_FFF0, 1'b1, 1'b1, 1'b1},
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0},
    '{32'hC000_0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_i = 1'b0;
  logic [W-1:0] dvd_i = '0;
  logic [W-1:0] dvs_i = '0;
  logic         q_i = 1'b0;
  logic         m_i = 1'b0;
  logic         t_i = 1'b0;
  logic [W-1:0] rem_o;
  logic         q_o;
  logic         t_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  divstep_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .dvd_i(dvd_i), .dvs_i(dvs_i), .q_i(q_i), .m_i(m_i), .t_i(t_i),
    .rem_o(rem_o), .q_o(q_o), .t_o(t_o)
  );

  // Reference model written from the requirements: 33-bit arithmetic and
  // an explicit four-way table for the new q.
  task automatic ref_step(input vec_t v, output logic [W-1:0] r,
                          output logic qn, output logic tn);
    logic [W-1:0] sh;
    logic         out_bit;
    logic [W:0]   wide;
    logic         f;
    sh      = {v.dvd[W-2:0], v.t};
    out_bit = v.dvd[W-1];
    if (v.q == v.m) wide = {1'b0, sh} - {1'b0, v.dvs};
    else            wide = {1'b0, sh} + {1'b0, v.dvs};
    r = wide[W-1:0];
    if (v.q == v.m) f = (r > sh);
    else            f = (r < sh);
    case ({v.q, v.m})
      2'b00:   qn = out_bit ? ~f : f;
      2'b01:   qn = out_bit ? f : ~f;
      2'b10:   qn = out_bit ? f : ~f;
      default: qn = out_bit ? ~f : f;
    endcase
    tn = (qn == v.m);
  endtask

  task automatic chk_rem(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rem: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, nm, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic stp);
    dvd_i = v.dvd; dvs_i = v.dvs; q_i = v.q; m_i = v.m; t_i = v.t;
    step_i = stp;
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] er, prev_r;
    logic eq, et, prev_q, prev_t;
    vec_t v;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk_rem("R1", rem_o, '0);
    chk_bit("R1", "q", q_o, 1'b0);
    chk_bit("R1", "t", t_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_rem("R1", rem_o, '0);

    // Vector table: R2..R7 through the shift, add/sub, flag and q/t rules
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i], 1'b1);
      @(negedge clk);
      step_i = 1'b0;
      ref_step(VEC[i], er, eq, et);
      chk_rem((VEC[i].q == VEC[i].m) ? "R3" : "R4", rem_o, er);
      chk_bit("R6", "q", q_o, eq);
      chk_bit("R7", "t", t_o, et);
    end

    // R2: t_i fills bit 0 (subtract zero to expose the raw shift)
    v = '{32'h0000_00F0, 32'h0, 1'b0, 1'b0, 1'b1};
    apply(v, 1'b1);
    @(negedge clk);
    step_i = 1'b0;
    chk_rem("R2", rem_o, 32'h0000_01E1);

    // R5: borrow sets flag (q=m=0, msb 0 -> q = flag = 1)
    v = '{32'h0000_0002, 32'h0000_0010, 1'b0, 1'b0, 1'b0};
    apply(v, 1'b1);
    @(negedge clk);
    step_i = 1'b0;
    chk_bit("R5", "q", q_o, 1'b1);
    // R5: carry sets flag (q=0,m=1, msb 1 -> q = flag = 1)
    v = '{32'hC000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b0};
    apply(v, 1'b1);
    @(negedge clk);
    step_i = 1'b0;
    chk_bit("R5", "q", q_o, 1'b1);
    chk_rem("R5", rem_o, 32'h0);

    // R8: step low, inputs change, outputs hold
    prev_r = rem_o; prev_q = q_o; prev_t = t_o;
    v = '{32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1, 1'b0, 1'b1};
    apply(v, 1'b0);
    repeat (3) @(negedge clk);
    chk_rem("R8", rem_o, prev_r);
    chk_bit("R8", "q", q_o, prev_q);
    chk_bit("R8", "t", t_o, prev_t);

    // R9: back-to-back steps fed from registered outputs
    v = '{32'h0000_0007, 32'h0000_0003, 1'b0, 1'b0, 1'b0};
    apply(v, 1'b1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ref_step(v, er, eq, et);
      chk_rem("R9", rem_o, er);
      chk_bit("R9", "q", q_o, eq);
      chk_bit("R9", "t", t_o, et);
      v = '{rem_o, v.dvs, q_o, v.m, t_o};
      apply(v, (k < 3));
    end

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk_rem("R1", rem_o, '0);
    chk_bit("R1", "q", q_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule